// File: doc/BRIEF.md
# Teletext Request Window Generator

This block produces the teletext data request strobe for a video encoder back end. It watches the encoder's pixel and line counters and the field identifier. On every line that lies inside the programmed window of the current field, it raises a request at a programmable horizontal position and holds it for a fixed number of pixel clocks. The odd and even fields each have their own window, given as a pair of 9-bit codes. The first and last lines of a window are biased differently for 525-line (M) timing and for 625-line timing. A 16-bit kill mask can suppress single lines inside those windows.

A second output tells the data path when to capture. It is a one-clock strobe that follows the request's rising edge by a programmable delay in clocks. The delay has a floor of two clocks. All configuration arrives as static inputs. The request and the strobe are registered. The reset is asynchronous and active low, and it is released through a two-stage synchronizer.

Top module: `ttx_req_gen`

## Requirements
- R1: While `ttx_en` is 0, `req_o` is 0 one clock later, whatever the counters show.
- R2: On an accepted line, `req_o` rises in the clock after the one in which `pix_cnt` equals `hstart`.
- R3: `req_o` is 1 in the clock after each cycle where `hstart <= pix_cnt < hstart + REQ_LEN` on an accepted line, and 0 after every other cycle of that line.
- R4: The first line of a field's window is its first code plus 4 when `std_525` is 1, and plus 1 when `std_525` is 0.
- R5: The last line of a field's window is its last code plus 3 when `std_525` is 1, and the code itself when `std_525` is 0.
- R6: `field_even` = 0 selects the `odd_first`/`odd_last` window and `field_even` = 1 selects the `even_first`/`even_last` window.
- R7: Bit i of `line_kill` set to 1 suppresses the request on line 5+i in both fields. Lines outside 5..20 and lines outside the window are not affected by the mask.
- R8: `data_vld_o` is a single-clock pulse, high exactly D clocks after the first clock in which `req_o` is 1, where D is `data_dly` as sampled at that rise.
- R9: A `data_dly` below 2 behaves as 2.
- R10: While `rst_n` is low, `req_o` and `data_vld_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_cnt | input | PIX_W | Pixel position within the line |
| line_cnt | input | LINE_W | Line number within the field |
| field_even | input | 1 | 0 = odd field, 1 = even field |
| ttx_en | input | 1 | Teletext request enable |
| std_525 | input | 1 | 1 = 525-line M timing, 0 = 625-line timing |
| hstart | input | 8 | Horizontal position where the request starts |
| data_dly | input | 4 | Clocks from request rise to data capture (minimum 2) |
| odd_first | input | 9 | Odd field first-line code |
| odd_last | input | 9 | Odd field last-line code |
| even_first | input | 9 | Even field first-line code |
| even_last | input | 9 | Even field last-line code |
| line_kill | input | 16 | Per-line suppression mask for lines 5..20 |
| req_o | output | 1 | Teletext data request |
| data_vld_o | output | 1 | Data capture strobe |

## Verification
A fault in a window comparator or a bias shows up as an extra or missing request on the first or last line of a field. It appears within one line time of the boundary, so both field windows, both line standards and several masks are swept over whole fields. A fault in the horizontal gate moves the rising or falling edge of `req_o` on every accepted line. The bench checks each clock and catches it on the first active line. A corrupted delay count appears as a strobe that comes early, late, twice or not at all, within at most 15 clocks of each rise. Every rise is followed to its strobe, including the delay settings below the floor.

// File: rtl/ttx_req_pkg.sv
package ttx_req_pkg;

  localparam int CODE_W     = 9;
  localparam int HS_W       = 8;
  localparam int DLY_W      = 4;
  localparam int KILL_N     = 16;
  localparam int KILL_FIRST = 5;
  localparam int DLY_MIN    = 2;

  // typical power-on settings per line standard
  localparam logic [HS_W-1:0]   HS_DEF_625    = 8'h42;
  localparam logic [HS_W-1:0]   HS_DEF_525    = 8'h54;
  localparam logic [CODE_W-1:0] ODD_FIRST_625 = 9'h005;
  localparam logic [CODE_W-1:0] ODD_FIRST_525 = 9'h006;
  localparam logic [CODE_W-1:0] EVN_FIRST_625 = 9'h004;
  localparam logic [CODE_W-1:0] EVN_FIRST_525 = 9'h005;
  localparam logic [CODE_W-1:0] LAST_625      = 9'h016;
  localparam logic [CODE_W-1:0] LAST_525      = 9'h010;

  typedef struct packed {
    logic [CODE_W-1:0] first_code;
    logic [CODE_W-1:0] last_code;
  } field_codes_t;

  function automatic logic [2:0] first_bias(input logic std_525);
    return std_525 ? 3'd4 : 3'd1;
  endfunction

  function automatic logic [2:0] last_bias(input logic std_525);
    return std_525 ? 3'd3 : 3'd0;
  endfunction

endpackage

// File: rtl/ttx_rst_sync.sv
module ttx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage0_q;
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage0_q <= 1'b0;
      stage1_q <= 1'b0;
    end else begin
      stage0_q <= 1'b1;
      stage1_q <= stage0_q;
    end
  end

  assign rst_sync_n = stage1_q;

endmodule

// File: rtl/ttx_line_win.sv
module ttx_line_win
  import ttx_req_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              std_525,
  input  field_codes_t      codes,
  output logic              in_win
);

  localparam int CMP_W = ((LINE_W > CODE_W) ? LINE_W : CODE_W) + 1;

  logic [CMP_W-1:0] line_ext;
  logic [CMP_W-1:0] lo_line;
  logic [CMP_W-1:0] hi_line;

  always_comb begin
    line_ext = CMP_W'(line_cnt);
    lo_line  = CMP_W'(codes.first_code) + CMP_W'(first_bias(std_525));
    hi_line  = CMP_W'(codes.last_code)  + CMP_W'(last_bias(std_525));
    in_win   = (line_ext >= lo_line) && (line_ext <= hi_line);
  end

endmodule

// File: rtl/ttx_line_kill.sv
module ttx_line_kill #(
  parameter int LINE_W     = 10,
  parameter int KILL_FIRST = 5,
  parameter int KILL_N     = 16
) (
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [KILL_N-1:0] kill_mask,
  output logic              killed
);

  localparam int IDX_W = $clog2(KILL_N);
  localparam int CW    = LINE_W + 1;

  logic [CW-1:0]    offset;
  logic             in_range;
  logic [IDX_W-1:0] idx;

  always_comb begin
    offset   = CW'(line_cnt) - CW'(KILL_FIRST);
    in_range = (CW'(line_cnt) >= CW'(KILL_FIRST)) && (offset < CW'(KILL_N));
    idx      = offset[IDX_W-1:0];
    killed   = in_range && kill_mask[idx];
  end

endmodule

// File: rtl/ttx_hgate.sv
module ttx_hgate #(
  parameter int PIX_W   = 11,
  parameter int HS_W    = 8,
  parameter int REQ_LEN = 360
) (
  input  logic [PIX_W-1:0] pix_cnt,
  input  logic [HS_W-1:0]  hstart,
  output logic             in_hwin
);

  localparam int BASE_W = (PIX_W > HS_W) ? PIX_W : HS_W;
  localparam int SUM_W  = BASE_W + $clog2(REQ_LEN + 1) + 1;

  logic [SUM_W-1:0] pix_ext;
  logic [SUM_W-1:0] win_lo;
  logic [SUM_W-1:0] win_hi;

  always_comb begin
    pix_ext = SUM_W'(pix_cnt);
    win_lo  = SUM_W'(hstart);
    win_hi  = SUM_W'(hstart) + SUM_W'(REQ_LEN);
    in_hwin = (pix_ext >= win_lo) && (pix_ext < win_hi);
  end

endmodule

// File: rtl/ttx_data_strobe.sv
module ttx_data_strobe #(
  parameter int DLY_W   = 4,
  parameter int DLY_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] dly,
  output logic             strobe
);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             cnt_en;
  logic [DLY_W-1:0] dly_eff;
  logic             stb_q;
  logic             stb_d;

  always_comb begin
    dly_eff = (dly < DLY_W'(DLY_MIN)) ? DLY_W'(DLY_MIN) : dly;
    cnt_en  = load || (cnt_q != '0);
    if (load) begin
      cnt_d = dly_eff;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    stb_d = (cnt_q == DLY_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  assign strobe = stb_q;

endmodule

// File: rtl/ttx_req_gen.sv
module ttx_req_gen
  import ttx_req_pkg::*;
#(
  parameter int PIX_W   = 11,
  parameter int LINE_W  = 10,
  parameter int REQ_LEN = 360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              field_even,
  input  logic              ttx_en,
  input  logic              std_525,
  input  logic [7:0]        hstart,
  input  logic [3:0]        data_dly,
  input  logic [8:0]        odd_first,
  input  logic [8:0]        odd_last,
  input  logic [8:0]        even_first,
  input  logic [8:0]        even_last,
  input  logic [15:0]       line_kill,
  output logic              req_o,
  output logic              data_vld_o
);

  localparam int NFIELD = 2;

  logic         rst_sync_n;
  field_codes_t codes [NFIELD];
  logic [NFIELD-1:0] win_hit;
  logic         line_ok;
  logic         killed;
  logic         in_hwin;
  logic         req_d;
  logic         req_q;
  logic         req_rise;

  ttx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign codes[0] = '{first_code: odd_first,  last_code: odd_last};
  assign codes[1] = '{first_code: even_first, last_code: even_last};

  for (genvar gf = 0; gf < NFIELD; gf++) begin : g_field
    ttx_line_win #(.LINE_W(LINE_W)) u_win (
      .line_cnt (line_cnt),
      .std_525  (std_525),
      .codes    (codes[gf]),
      .in_win   (win_hit[gf])
    );
  end

  ttx_line_kill #(
    .LINE_W     (LINE_W),
    .KILL_FIRST (KILL_FIRST),
    .KILL_N     (KILL_N)
  ) u_kill (
    .line_cnt  (line_cnt),
    .kill_mask (line_kill),
    .killed    (killed)
  );

  ttx_hgate #(
    .PIX_W   (PIX_W),
    .HS_W    (HS_W),
    .REQ_LEN (REQ_LEN)
  ) u_hgate (
    .pix_cnt (pix_cnt),
    .hstart  (hstart),
    .in_hwin (in_hwin)
  );

  always_comb begin
    line_ok  = field_even ? win_hit[1] : win_hit[0];
    req_d    = ttx_en && line_ok && !killed && in_hwin;
    req_rise = req_d && !req_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  ttx_data_strobe #(
    .DLY_W   (DLY_W),
    .DLY_MIN (DLY_MIN)
  ) u_stb (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (req_rise),
    .dly    (data_dly),
    .strobe (data_vld_o)
  );

  assign req_o = req_q;

endmodule

// File: rtl/ttx_req_gen_chk.sv
module ttx_req_gen_chk #(
  parameter int PIX_W   = 11,
  parameter int LINE_W  = 10,
  parameter int REQ_LEN = 360
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input logic              ttx_en,
  input logic [7:0]        hstart,
  input logic [15:0]       line_kill,
  input logic              req_o,
  input logic              data_vld_o
);

  localparam int CW    = LINE_W + 1;
  localparam int SUM_W = PIX_W + $clog2(REQ_LEN + 1) + 2;

  logic [CW-1:0] kofs;
  logic          kill_hit;
  logic [SUM_W-1:0] hs_lo;
  logic [SUM_W-1:0] hs_hi;
  logic [SUM_W-1:0] pix_x;

  always_comb begin
    kofs     = CW'(line_cnt) - CW'(5);
    kill_hit = (CW'(line_cnt) >= CW'(5)) && (kofs < CW'(16)) && line_kill[kofs[3:0]];
    hs_lo    = SUM_W'(hstart);
    hs_hi    = SUM_W'(hstart) + SUM_W'(REQ_LEN);
    pix_x    = SUM_W'(pix_cnt);
  end

  AST_REQ_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ttx_en |=> !req_o); // R1

  AST_REQ_IN_HWIN: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> ($past(pix_x) >= $past(hs_lo)) && ($past(pix_x) < $past(hs_hi))); // R3

  AST_KILL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    kill_hit |=> !req_o); // R7

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    data_vld_o |=> !data_vld_o); // R8

  AST_STB_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |=> !data_vld_o); // R9

endmodule

bind ttx_req_gen ttx_req_gen_chk #(
  .PIX_W   (PIX_W),
  .LINE_W  (LINE_W),
  .REQ_LEN (REQ_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_cnt    (pix_cnt),
  .line_cnt   (line_cnt),
  .ttx_en     (ttx_en),
  .hstart     (hstart),
  .line_kill  (line_kill),
  .req_o      (req_o),
  .data_vld_o (data_vld_o)
);

// File: tb/ttx_req_gen_test.sv
module ttx_req_gen_test;

  localparam int PIX_W   = 11;
  localparam int LINE_W  = 10;
  localparam int REQ_LEN = 20;
  localparam int NPIX    = 64;
  localparam int NLINE   = 28;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              field_even;
  logic              ttx_en;
  logic              std_525;
  logic [7:0]        hstart;
  logic [3:0]        data_dly;
  logic [8:0]        odd_first, odd_last, even_first, even_last;
  logic [15:0]       line_kill;
  logic              req_o;
  logic              data_vld_o;

  always #10 clk = ~clk;

  ttx_req_gen #(.PIX_W(PIX_W), .LINE_W(LINE_W), .REQ_LEN(REQ_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .field_even(field_even), .ttx_en(ttx_en), .std_525(std_525),
    .hstart(hstart), .data_dly(data_dly), .odd_first(odd_first),
    .odd_last(odd_last), .even_first(even_first), .even_last(even_last),
    .line_kill(line_kill), .req_o(req_o), .data_vld_o(data_vld_o)
  );

  int    n_run = 0;
  int    n_fail = 0;
  int    k = 0;
  bit    done = 0;
  bit    exp_now = 0, exp_nxt = 0, vld_nxt = 0;
  int    rk = -100, rd = 2, pk = -100, pd = 2;
  bit    pend = 0;
  string req_tag = "R10", vld_tag = "R8";

  task automatic chk(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (sample %0d)", tag, what, act, exp, k);
    end
  endtask

  function automatic bit in_win(int ln, bit fe);
    int lo, hi;
    lo = (fe ? int'(even_first) : int'(odd_first)) + (std_525 ? 4 : 1);
    hi = (fe ? int'(even_last) : int'(odd_last)) + (std_525 ? 3 : 0);
    return (ln >= lo) && (ln <= hi);
  endfunction

  function automatic bit masked(int ln);
    return (ln >= 5) && (ln <= 20) && line_kill[ln-5];
  endfunction

  function automatic bit model();
    int p, ln;
    p  = int'(pix_cnt);
    ln = int'(line_cnt);
    return ttx_en && in_win(ln, field_even) && !masked(ln) &&
           (p >= int'(hstart)) && (p < int'(hstart) + REQ_LEN);
  endfunction

  function automatic string tag_of();
    int ln, lo, hi;
    ln = int'(line_cnt);
    lo = (field_even ? int'(even_first) : int'(odd_first)) + (std_525 ? 4 : 1);
    hi = (field_even ? int'(even_last) : int'(odd_last)) + (std_525 ? 3 : 0);
    if (!ttx_en) return "R1";
    if (in_win(ln, field_even) && masked(ln)) return "R7";
    if (ln == lo || ln == lo - 1) return "R4";
    if (ln == hi || ln == hi + 1) return "R5";
    if (in_win(ln, field_even) != in_win(ln, !field_even)) return "R6";
    if (int'(pix_cnt) == int'(hstart)) return "R2";
    return "R3";
  endfunction

  // expectation for the sample after the coming clock edge
  task automatic eval();
    exp_nxt = model();
    req_tag = tag_of();
    if (exp_nxt && !exp_now) begin
      pend = 1; pk = k + 1; pd = (data_dly < 2) ? 2 : int'(data_dly);
      vld_nxt = 0;
    end else begin
      pend = 0;
      vld_nxt = ((k + 1) == rk + rd);
    end
  endtask

  task automatic cycle(int p, int ln, bit fe);
    @(negedge clk);
    k++;
    chk(req_tag, "req_o", req_o, exp_nxt);
    chk(vld_tag, "data_vld_o", data_vld_o, vld_nxt);
    exp_now = exp_nxt;
    if (pend) begin
      rk = pk; rd = pd;
      vld_tag = (int'(data_dly) < 2) ? "R9" : "R8";
    end
    pix_cnt = PIX_W'(p); line_cnt = LINE_W'(ln); field_even = fe;
    eval();
  endtask

  task automatic frame();
    for (int f = 0; f < 2; f++)
      for (int ln = 0; ln < NLINE; ln++)
        for (int p = 0; p < NPIX; p++)
          cycle(p, ln, f[0]);
  endtask

  task automatic set_std(bit m);
    std_525    = m;
    odd_first  = m ? 9'h006 : 9'h005;
    even_first = m ? 9'h005 : 9'h004;
    odd_last   = m ? 9'h010 : 9'h016;
    even_last  = m ? 9'h010 : 9'h016;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hs_t [4];
    int dl_t [4];
    bit en_t [4];
    logic [15:0] km [3];
    hs_t = '{10, 50, 0, 30};
    dl_t = '{0, 15, 2, 7};
    en_t = '{1, 1, 1, 0};
    km   = '{16'h0000, 16'hA5C3, 16'hFFFF};

    rst_n = 0; ttx_en = 1; set_std(0); hstart = 8'd0; data_dly = 4'd2;
    line_kill = 16'h0; pix_cnt = '0; line_cnt = LINE_W'(10); field_even = 0;
    repeat (4) begin
      @(negedge clk);
      chk("R10", "req_o in reset", req_o, 1'b0);
      chk("R10", "data_vld_o in reset", data_vld_o, 1'b0);
    end
    ttx_en = 0;
    rst_n = 1;
    eval();
    repeat (4) cycle(0, 0, 0);

    for (int s = 0; s < 2; s++)
      for (int mi = 0; mi < 3; mi++)
        for (int ti = 0; ti < 4; ti++) begin
          set_std(s[0]); line_kill = km[mi];
          hstart = 8'(hs_t[ti]); data_dly = 4'(dl_t[ti]); ttx_en = en_t[ti];
          eval();
          frame();
        end

    // separate codes per field, 9-bit code beyond the raster, and delay 1
    for (int s = 0; s < 2; s++) begin
      std_525 = s[0]; line_kill = 16'h0F0F; hstart = 8'd5; data_dly = 4'd1;
      ttx_en = 1;
      odd_first = 9'h100; odd_last = 9'h1FF;
      even_first = 9'h000; even_last = 9'd27;
      eval();
      frame();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule